// File: doc/BRIEF.md
# Error completion packet streamer

This block sends the completion that answers a rejected request, one that ends with an Unsupported Request or Completer Abort status. The descriptor builder supplies a three-Dword completion descriptor together with a trigger. On that trigger the block also latches the four request descriptor Dwords and the request's byte-enable and processing-hint sideband. It then streams one eight-Dword packet on an AXI4-Stream source port. The receiver uses the request copy at the end of the packet to fill its error header log.

The data width is a parameter of 64, 128 or 256 bits, so the packet takes 4, 2 or 1 beats. The Dwords are packed without gaps. The packing does not change with the link's alignment mode, so the block has no alignment input. The port obeys sink backpressure, keeps valid high for the whole packet and flags the final beat. A trigger that arrives while a packet is still in flight is dropped.

Top module: `errcpl_streamer`

## Requirements
- R1: A packet is 8 Dwords sent in 256/DATA_W beats (4, 2 or 1). `m_tlast` is high on the final beat only.
- R2: Packet Dword n goes out in beat n/(DATA_W/32), at bits [32*(n mod (DATA_W/32)) +: 32]. Dwords 0..2 are `cpl_desc[32i +: 32]`, Dword 3 is the sideband summary, and Dwords 4..7 are `rq_desc[32j +: 32]` for j = 0..3.
- R3: The sideband summary Dword holds first byte enable in [3:0], last byte enable in [7:4], hint present in [8], hint type in [10:9] and steering tag in [18:11]. Bits [31:19] are zero.
- R4: `m_tkeep` is all ones on every beat where `m_tvalid` is high.
- R5: Once the first beat is offered, `m_tvalid` stays high on every cycle until the final beat is accepted.
- R6: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tkeep`, `m_tlast` and `m_tvalid` hold their values into the next cycle.
- R7: `cpl_start` while `busy` is low is accepted at that clock edge. `busy` and `m_tvalid` are high from the next cycle until the edge where the final beat is accepted, and low after it.
- R8: `cpl_start` while `busy` is high is ignored, including in the cycle the final beat is accepted. No extra packet is sent and the packet in flight is unchanged.
- R9: All packet fields are sampled at the accepted trigger. Changing the inputs afterwards does not change the packet.
- R10: `status_abort` takes the value of `cpl_abort` at the accepted trigger (1 = Completer Abort, 0 = Unsupported Request) and holds it until the next accepted trigger. The packet layout is the same for both values.
- R11: During reset `busy`, `m_tvalid` and `m_tlast` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_start | input | 1 | Trigger to send one error completion |
| cpl_abort | input | 1 | Status select at trigger: 1 Completer Abort, 0 Unsupported Request |
| cpl_desc | input | 96 | Completion descriptor, Dword 0 in bits [31:0] |
| rq_desc | input | 128 | Request descriptor, first received Dword in bits [31:0] |
| rq_first_be | input | 4 | Request first byte enable |
| rq_last_be | input | 4 | Request last byte enable |
| rq_hint_present | input | 1 | Request carries a processing hint |
| rq_hint_type | input | 2 | Processing hint type |
| rq_steer_tag | input | 8 | Processing hint steering tag |
| busy | output | 1 | A packet is in flight |
| status_abort | output | 1 | Latched status select for the descriptor builder |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/32 | Stream Dword keep |
| m_tlast | output | 1 | Final beat of the packet |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |

## Verification
Two functions can fall in the same cycle. One is a new trigger and the other is acceptance of the final beat, which ends the busy period. The bench is built with three widths, each with its own trigger. For each width it raises the trigger exactly on the edge where that width's final beat is accepted, with the sink always ready and new field values on the inputs. It judges the result by checking that `busy` is low in the following cycle and that exactly one packet, carrying the old data, was counted. It then checks that a later trigger is still accepted. Backpressure held across a dropped trigger is also exercised, and there the sent data must match the values latched first.

// File: rtl/errcpl_streamer.sv
module errcpl_streamer #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpl_start,
  input  logic              cpl_abort,
  input  logic [95:0]       cpl_desc,
  input  logic [127:0]      rq_desc,
  input  logic [3:0]        rq_first_be,
  input  logic [3:0]        rq_last_be,
  input  logic              rq_hint_present,
  input  logic [1:0]        rq_hint_type,
  input  logic [7:0]        rq_steer_tag,
  output logic              busy,
  output logic              status_abort,
  output logic [DATA_W-1:0] m_tdata,
  output logic [DATA_W/32-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  localparam int PKT_W = 256;
  localparam int BEATS = PKT_W / DATA_W;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  if (DATA_W != 64 && DATA_W != 128 && DATA_W != 256) begin : g_bad_width
    $error("errcpl_streamer: DATA_W must be 64, 128 or 256");
  end

  logic [PKT_W-1:0] pkt_q;
  logic [BW-1:0]    beat_q;
  logic             active_q;
  logic [31:0]      summary;
  logic             take;
  logic             at_end;

  assign summary = {13'd0, rq_steer_tag, rq_hint_type, rq_hint_present,
                    rq_last_be, rq_first_be};
  assign take    = cpl_start && !active_q;
  assign at_end  = (beat_q == BW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      beat_q       <= '0;
      pkt_q        <= '0;
      status_abort <= 1'b0;
    end else if (take) begin
      active_q     <= 1'b1;
      beat_q       <= '0;
      pkt_q        <= {rq_desc, summary, cpl_desc};
      status_abort <= cpl_abort;
    end else if (active_q && m_tready) begin
      if (at_end) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  if (BEATS == 1) begin : g_one
    assign m_tdata = pkt_q;
  end else begin : g_multi
    logic [BEATS-1:0][DATA_W-1:0] slices;
    assign slices  = pkt_q;
    assign m_tdata = slices[beat_q];
  end

  assign busy     = active_q;
  assign m_tvalid = active_q;
  assign m_tlast  = active_q && at_end;
  assign m_tkeep  = active_q ? '1 : '0;
endmodule

module errcpl_streamer_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpl_start,
  input logic              busy,
  input logic              status_abort,
  input logic [DATA_W-1:0] m_tdata,
  input logic [DATA_W/32-1:0] m_tkeep,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready
);
  localparam int BEATS = 256 / DATA_W;
  int acc_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_cnt <= 0;
    else if (m_tvalid && m_tready) acc_cnt <= m_tlast ? 0 : acc_cnt + 1;
  end

  // R1
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (m_tlast == (acc_cnt == BEATS - 1)));
  // R4
  keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> (&m_tkeep));
  // R5
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !(m_tready && m_tlast)) |=> m_tvalid);
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tkeep)));
  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_start && !busy) |=> (busy && m_tvalid));
  // R7
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(m_tvalid && m_tready && m_tlast)) |=> (busy && $stable(status_abort)));
endmodule

bind errcpl_streamer errcpl_streamer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpl_start(cpl_start), .busy(busy),
  .status_abort(status_abort), .m_tdata(m_tdata), .m_tkeep(m_tkeep),
  .m_tlast(m_tlast), .m_tvalid(m_tvalid), .m_tready(m_tready));

// File: tb/errcpl_streamer_tb.sv
module errcpl_stream_mon #(
  parameter int W = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tvalid,
  input  logic           tready,
  input  logic [W-1:0]   tdata,
  input  logic [W/32-1:0] tkeep,
  input  logic           tlast,
  input  logic [255:0]   exp_pkt,
  output int             nchk,
  output int             nbad,
  output int             npk
);
  localparam int B = 256 / W;
  int beat;
  logic hold;
  logic [W-1:0] hd;
  logic hl;

  initial begin
    nchk = 0; nbad = 0; npk = 0; beat = 0; hold = 0; hd = '0; hl = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      beat = 0; hold = 0;
    end else begin
      if (hold) begin
        nchk++;
        if (!tvalid || tdata !== hd || tlast !== hl) begin
          nbad++;
          $display("FAIL R6 W=%0d hold act=%h/%b exp=%h/%b", W, tdata, tlast, hd, hl);
        end
      end else if (beat > 0) begin
        nchk++;
        if (!tvalid) begin
          nbad++;
          $display("FAIL R5 W=%0d gap act=%b exp=1", W, tvalid);
        end
      end
      if (tvalid && tready) begin
        nchk++;
        if (tdata !== exp_pkt[beat*W +: W]) begin
          nbad++;
          $display("FAIL R2/R3/R9 W=%0d beat %0d act=%h exp=%h", W, beat, tdata, exp_pkt[beat*W +: W]);
        end
        nchk++;
        if (tlast !== (beat == B - 1)) begin
          nbad++;
          $display("FAIL R1 W=%0d beat %0d tlast act=%b exp=%b", W, beat, tlast, beat == B - 1);
        end
        nchk++;
        if (tkeep !== '1) begin
          nbad++;
          $display("FAIL R4 W=%0d tkeep act=%h exp=all ones", W, tkeep);
        end
        if (beat == B - 1) begin beat = 0; npk++; end
        else beat++;
      end
      hold = tvalid && !tready;
      hd = tdata;
      hl = tlast;
    end
  end
endmodule

module errcpl_streamer_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #2.5 clk = ~clk;

  logic [2:0]   st = '0;
  logic         abort = 0;
  logic [95:0]  cpl = '0;
  logic [127:0] rdesc = '0;
  logic [3:0]   fbe = '0, lbe = '0;
  logic         hp = 0;
  logic [1:0]   ht = '0;
  logic [7:0]   tag = '0;
  logic         rdy = 0;
  logic         bp_en = 0;
  logic [255:0] exp0 = '0, exp1 = '0, exp2 = '0;

  logic [2:0] bsy, stat, tv, tl;
  logic [63:0]  d0; logic [127:0] d1; logic [255:0] d2;
  logic [1:0] k0; logic [3:0] k1; logic [7:0] k2;
  int c0, c1, c2, b0, b1, b2, p0, p1, p2;
  int total = 0, bad = 0;

  errcpl_streamer #(.DATA_W(64)) u_dut64 (
    .clk(clk), .rst_n(rst_n), .cpl_start(st[0]), .cpl_abort(abort), .cpl_desc(cpl),
    .rq_desc(rdesc), .rq_first_be(fbe), .rq_last_be(lbe), .rq_hint_present(hp),
    .rq_hint_type(ht), .rq_steer_tag(tag), .busy(bsy[0]), .status_abort(stat[0]),
    .m_tdata(d0), .m_tkeep(k0), .m_tlast(tl[0]), .m_tvalid(tv[0]), .m_tready(rdy));
  errcpl_streamer #(.DATA_W(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpl_start(st[1]), .cpl_abort(abort), .cpl_desc(cpl),
    .rq_desc(rdesc), .rq_first_be(fbe), .rq_last_be(lbe), .rq_hint_present(hp),
    .rq_hint_type(ht), .rq_steer_tag(tag), .busy(bsy[1]), .status_abort(stat[1]),
    .m_tdata(d1), .m_tkeep(k1), .m_tlast(tl[1]), .m_tvalid(tv[1]), .m_tready(rdy));
  errcpl_streamer #(.DATA_W(256)) u_dut256 (
    .clk(clk), .rst_n(rst_n), .cpl_start(st[2]), .cpl_abort(abort), .cpl_desc(cpl),
    .rq_desc(rdesc), .rq_first_be(fbe), .rq_last_be(lbe), .rq_hint_present(hp),
    .rq_hint_type(ht), .rq_steer_tag(tag), .busy(bsy[2]), .status_abort(stat[2]),
    .m_tdata(d2), .m_tkeep(k2), .m_tlast(tl[2]), .m_tvalid(tv[2]), .m_tready(rdy));

  errcpl_stream_mon #(.W(64))  u_m0 (.clk(clk), .rst_n(rst_n), .tvalid(tv[0]), .tready(rdy),
    .tdata(d0), .tkeep(k0), .tlast(tl[0]), .exp_pkt(exp0), .nchk(c0), .nbad(b0), .npk(p0));
  errcpl_stream_mon #(.W(128)) u_m1 (.clk(clk), .rst_n(rst_n), .tvalid(tv[1]), .tready(rdy),
    .tdata(d1), .tkeep(k1), .tlast(tl[1]), .exp_pkt(exp1), .nchk(c1), .nbad(b1), .npk(p1));
  errcpl_stream_mon #(.W(256)) u_m2 (.clk(clk), .rst_n(rst_n), .tvalid(tv[2]), .tready(rdy),
    .tdata(d2), .tkeep(k2), .tlast(tl[2]), .exp_pkt(exp2), .nchk(c2), .nbad(b2), .npk(p2));

  logic [31:0] lfsr = 32'h1ace_b00c;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    if (bp_en) rdy = lfsr[3] | lfsr[7];
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  function automatic logic [255:0] model();
    return {rdesc, 13'd0, tag, ht, hp, lbe, fbe, cpl};
  endfunction

  task automatic new_fields();
    cpl   = {$urandom, $urandom, $urandom};
    rdesc = {$urandom, $urandom, $urandom, $urandom};
    fbe = 4'($urandom); lbe = 4'($urandom); hp = 1'($urandom);
    ht = 2'($urandom); tag = 8'($urandom);
  endtask

  task automatic fire(input logic [2:0] mask, input logic ab);
    @(posedge clk); #1;
    new_fields();
    abort = ab;
    if (mask[0]) exp0 = model();
    if (mask[1]) exp1 = model();
    if (mask[2]) exp2 = model();
    st = mask;
    @(posedge clk); #1;
    st = '0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && bsy != 3'b000; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bsy == 0 && tv == 0 && tl == 0, "R11 reset outputs", {bsy, tv, tl}, 0);
  endtask

  task automatic t_plain(input logic ab);
    int q0 = p0, q1 = p1, q2 = p2;
    rdy = 1;
    fire(3'b111, ab);
    @(negedge clk);
    chk(bsy == 3'b111 && tv == 3'b111, "R7 busy after trigger", {bsy, tv}, 6'h3f);
    chk(stat == {3{ab}}, "R10 status latched", stat, {3{ab}});
    wait_idle();
    chk(p0 == q0 + 1 && p1 == q1 + 1 && p2 == q2 + 1, "R1 one packet per width",
        p0 + p1 + p2 - q0 - q1 - q2, 3);
    chk(bsy == 0 && tv == 0, "R7 idle after last beat", {bsy, tv}, 0);
  endtask

  task automatic t_backpressure();
    int q0 = p0, q1 = p1, q2 = p2;
    bp_en = 1;
    for (int r = 0; r < 6; r++) begin
      fire(3'b111, 1'($urandom));
      wait_idle();
    end
    bp_en = 0; rdy = 1;
    chk(p0 == q0 + 6 && p1 == q1 + 6 && p2 == q2 + 6, "R6 packets under backpressure",
        p0 + p1 + p2 - q0 - q1 - q2, 18);
  endtask

  task automatic t_busy_trigger();
    int q0 = p0, q1 = p1, q2 = p2;
    rdy = 0;
    fire(3'b111, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    new_fields();
    abort = 1;
    st = 3'b111;
    @(posedge clk); #1;
    st = '0;
    @(negedge clk);
    chk(bsy == 3'b111, "R8 busy kept", bsy, 7);
    chk(stat == 3'b000, "R8 R10 status unchanged by ignored trigger", stat, 0);
    new_fields();
    @(posedge clk); #1;
    rdy = 1;
    wait_idle();
    chk(p0 == q0 + 1 && p1 == q1 + 1 && p2 == q2 + 1, "R8 R9 single packet with latched data",
        p0 + p1 + p2 - q0 - q1 - q2, 3);
  endtask

  task automatic t_collide(input int k);
    int beats = (k == 0) ? 4 : (k == 1) ? 2 : 1;
    int q0 = p0, q1 = p1, q2 = p2;
    rdy = 1;
    fire(3'b001 << k, 1'b0);
    repeat (beats - 1) @(posedge clk);
    #1;
    new_fields();
    abort = 1;
    st = 3'b001 << k;
    @(posedge clk); #1;
    st = '0;
    @(negedge clk);
    chk(bsy[k] == 0, "R8 trigger on final beat ignored", bsy[k], 0);
    chk(stat[k] == 0, "R8 status after collision", stat[k], 0);
    repeat (3) @(negedge clk);
    chk((p0 - q0) + (p1 - q1) + (p2 - q2) == 1, "R8 no extra packet",
        (p0 - q0) + (p1 - q1) + (p2 - q2), 1);
    fire(3'b001 << k, 1'b1);
    @(negedge clk);
    chk(bsy[k] == 1 && stat[k] == 1, "R7 later trigger accepted", {bsy[k], stat[k]}, 3);
    wait_idle();
  endtask

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total + c0 + c1 + c2, bad + b0 + b1 + b2);
    $finish;
  end

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_plain(1'b0);
    t_plain(1'b1);
    t_backpressure();
    t_busy_trigger();
    for (int k = 0; k < 3; k++) t_collide(k);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total + c0 + c1 + c2, bad + b0 + b1 + b2);
    $finish;
  end
endmodule